// File: doc/BRIEF.md
# Vector Pipe Dispatch Guard

This block decides, in a single cycle, which of up to two candidate vector or floating-point operations may be sent this cycle to the two vector execution pipes, called pipe A and pipe B. Slot 0 always holds the older candidate and slot 1 the younger. Each candidate carries a 3-bit class code. The block returns a grant for each slot and the pipe chosen for each granted slot.

Pipe steering follows the class. Some classes are tied to one pipe. Scalar and vector floating-point operations may use either pipe. Two hazards are enforced in the same cycle. First, an operation that reads four single-precision inputs and is placed on pipe A keeps any floating-point operation off pipe B. Second, short fixed-point vector operations share a write-back port on pipe A with vector floating-point operations, and the two latencies differ by five cycles. A short operation is therefore refused on pipe A exactly five cycles after a vector floating-point operation was granted there. A DIST-deep history of those grants holds this state.

Dispatch is in order. A refused candidate stalls, and everything younger than it stalls too. Operand readiness and the execution datapaths belong to other blocks.

Top module: `vec_issue_guard`

## Requirements
- R1: Class 0 (vector integer) is only granted on pipe A (pipe code 0).
- R2: Class 4 (permute) and class 5 (128-bit store data) are only granted on pipe B (pipe code 1).
- R3: Class 1 (vector FP) and class 2 (scalar FP) take pipe A when it is free this cycle. Otherwise they take pipe B when allowed. Otherwise they are refused.
- R4: Each pipe accepts at most one operation per cycle. When the older slot is granted a pipe, the younger slot cannot be granted the same pipe.
- R5: Class 3 (four single-precision inputs) is only granted on pipe A. In a cycle where it is granted, a class 1 or class 2 operation in the other slot is not granted pipe B.
- R6: Class 6 (short fixed-point vector op) is only granted on pipe A. It is refused when a class 1 operation was granted on pipe A exactly DIST (default 5) cycles earlier. At distances of DIST-1 and DIST+1 it is not refused. Class 2 grants on pipe A, and class 1 grants on pipe B, do not cause this refusal.
- R7: Slot 1 is granted only when slot 0 is valid and granted. A refused or idle slot 0 stalls slot 1.
- R8: Class code 7 is reserved and is never granted. As the older slot it therefore stalls slot 1.
- R9: Reset clears the write-back history. A class 6 operation that would have hit the DIST-cycle window of a class 1 grant made before the reset is granted.
- R10: A slot that is not granted drives pipe code 0. With no valid input, both grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the history |
| s0_vld | input | 1 | Older candidate present |
| s0_op | input | 3 | Older candidate class code |
| s1_vld | input | 1 | Younger candidate present |
| s1_op | input | 3 | Younger candidate class code |
| s0_gnt | output | 1 | Older candidate dispatched this cycle |
| s0_pipe | output | 1 | Pipe for older candidate (0 = A, 1 = B) |
| s1_gnt | output | 1 | Younger candidate dispatched this cycle |
| s1_pipe | output | 1 | Pipe for younger candidate (0 = A, 1 = B) |

## Verification
The bench sweeps a window of gaps around the write-back distance, from 1 to 7 cycles between a vector-FP grant and a short op. An off-by-one history tap would refuse the short op at four or six cycles, or let it through at five. It also checks that the stall is passed down in order: a design that granted a younger slot behind a refused older one would let a permute run ahead of a blocked short op. Every pair of class codes is swept with and without live history. This catches a flexible FP op that is wrongly refused or double-books pipe A, and an FP op that is allowed onto pipe B beside a four-input op. A reset placed inside the window shows whether the history is really cleared.

// File: rtl/vig_pkg.sv
package vig_pkg;
   typedef enum logic [2:0] {
      OP_VINT  = 3'd0,
      OP_VFP   = 3'd1,
      OP_SFP   = 3'd2,
      OP_QUAD4 = 3'd3,
      OP_PERM  = 3'd4,
      OP_STDAT = 3'd5,
      OP_SHORT = 3'd6,
      OP_RSVD  = 3'd7
   } vop_e;

   localparam logic PIPE_A = 1'b0;
   localparam logic PIPE_B = 1'b1;
endpackage

// File: rtl/vig_steer.sv
module vig_steer
   import vig_pkg::*;
(
   input  logic vld,
   input  vop_e op,
   input  logic a_free,
   input  logic b_free,
   input  logic b_fp_ok,
   input  logic short_ok,
   output logic gnt,
   output logic pipe
);
   logic can;
   logic sel;

   always_comb begin
      can = 1'b0;
      sel = PIPE_A;
      case (op)
         OP_VINT:  can = a_free;
         OP_QUAD4: can = a_free;
         OP_SHORT: can = a_free & short_ok;
         OP_PERM, OP_STDAT: begin
            can = b_free;
            sel = PIPE_B;
         end
         OP_VFP, OP_SFP: begin
            if (a_free) begin
               can = 1'b1;
            end else if (b_free && b_fp_ok) begin
               can = 1'b1;
               sel = PIPE_B;
            end
         end
         default: can = 1'b0;
      endcase
   end

   assign gnt  = vld & can;
   assign pipe = gnt & sel;
endmodule

// File: rtl/vig_wb_hist.sv
module vig_wb_hist #(
   parameter int DIST = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   output logic hit
);
   generate
      if (DIST == 1) begin : g_single
         logic flag;
         always_ff @(posedge clk) begin
            if (!rst_n) flag <= 1'b0;
            else        flag <= push;
         end
         assign hit = flag;
      end else begin : g_shift
         logic [DIST-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[DIST-2:0], push};
         end
         assign hit = sr[DIST-1];
      end
   endgenerate
endmodule

// File: rtl/vec_issue_guard.sv
module vec_issue_guard
   import vig_pkg::*;
#(
   parameter int DIST = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       s0_vld,
   input  logic [2:0] s0_op,
   input  logic       s1_vld,
   input  logic [2:0] s1_op,
   output logic       s0_gnt,
   output logic       s0_pipe,
   output logic       s1_gnt,
   output logic       s1_pipe
);
   generate
      if (DIST < 1 || DIST > 64) begin : g_bad_dist
         $error("vec_issue_guard: DIST must lie in 1..64");
      end
   endgenerate

   vop_e op0;
   vop_e op1;
   logic wb_hit;
   logic wb_push;
   logic s0_on_a;
   logic s0_on_b;
   logic s0_quad_a;

   assign op0 = vop_e'(s0_op);
   assign op1 = vop_e'(s1_op);

   vig_wb_hist #(.DIST(DIST)) u_hist (
      .clk  (clk),
      .rst_n(rst_n),
      .push (wb_push),
      .hit  (wb_hit)
   );

   vig_steer u_old (
      .vld     (s0_vld),
      .op      (op0),
      .a_free  (1'b1),
      .b_free  (1'b1),
      .b_fp_ok (1'b1),
      .short_ok(~wb_hit),
      .gnt     (s0_gnt),
      .pipe    (s0_pipe)
   );

   assign s0_on_a   = s0_gnt & (s0_pipe == PIPE_A);
   assign s0_on_b   = s0_gnt & (s0_pipe == PIPE_B);
   assign s0_quad_a = s0_on_a & (op0 == OP_QUAD4);

   vig_steer u_young (
      .vld     (s1_vld & s0_gnt),
      .op      (op1),
      .a_free  (~s0_on_a),
      .b_free  (~s0_on_b),
      .b_fp_ok (~s0_quad_a),
      .short_ok(~wb_hit),
      .gnt     (s1_gnt),
      .pipe    (s1_pipe)
   );

   assign wb_push = (s0_on_a & (op0 == OP_VFP))
                  | (s1_gnt & (s1_pipe == PIPE_A) & (op1 == OP_VFP));
endmodule

// File: rtl/vec_issue_guard_chk.sv
module vec_issue_guard_chk #(
   parameter int DIST = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       s0_vld,
   input logic [2:0] s0_op,
   input logic       s1_vld,
   input logic [2:0] s1_op,
   input logic       s0_gnt,
   input logic       s0_pipe,
   input logic       s1_gnt,
   input logic       s1_pipe
);
   logic [DIST:0] seen;
   logic          vfp_a;

   assign vfp_a = (s0_gnt && s0_op == 3'd1 && !s0_pipe)
               || (s1_gnt && s1_op == 3'd1 && !s1_pipe);

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= '0;
      else        seen <= {seen[DIST-1:0], vfp_a};
   end

   // R1
   vint_pipe_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((s0_gnt && s0_op == 3'd0 && s0_pipe) || (s1_gnt && s1_op == 3'd0 && s1_pipe)));

   // R2
   pipe_b_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((s0_gnt && (s0_op == 3'd4 || s0_op == 3'd5) && !s0_pipe) ||
        (s1_gnt && (s1_op == 3'd4 || s1_op == 3'd5) && !s1_pipe)));

   // R4
   pipe_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_gnt && s1_gnt) |-> (s0_pipe != s1_pipe));

   // R5
   quad_fp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_gnt && s0_op == 3'd3 && s1_gnt && s1_pipe) |-> !(s1_op == 3'd1 || s1_op == 3'd2));

   // R6
   wb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((s0_gnt && s0_op == 3'd6) || (s1_gnt && s1_op == 3'd6)) |-> !seen[DIST-1]);

   // R7
   in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_gnt |-> (s0_gnt && s0_vld && s1_vld));

   // R8
   reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((s0_gnt && s0_op == 3'd7) || (s1_gnt && s1_op == 3'd7)));

   // R10
   idle_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((!s0_gnt && s0_pipe) || (!s1_gnt && s1_pipe)));
endmodule

bind vec_issue_guard vec_issue_guard_chk #(.DIST(DIST)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .s0_vld (s0_vld),
   .s0_op  (s0_op),
   .s1_vld (s1_vld),
   .s1_op  (s1_op),
   .s0_gnt (s0_gnt),
   .s0_pipe(s0_pipe),
   .s1_gnt (s1_gnt),
   .s1_pipe(s1_pipe)
);

// File: tb/tb_vec_issue_guard.sv
module tb_vec_issue_guard;
   localparam int DIST = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       s0_vld, s1_vld;
   logic [2:0] s0_op, s1_op;
   logic       s0_gnt, s0_pipe, s1_gnt, s1_pipe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [DIST-1:0] mh;

   always #2 clk = ~clk;

   vec_issue_guard #(.DIST(DIST)) dut (
      .clk(clk), .rst_n(rst_n),
      .s0_vld(s0_vld), .s0_op(s0_op), .s1_vld(s1_vld), .s1_op(s1_op),
      .s0_gnt(s0_gnt), .s0_pipe(s0_pipe), .s1_gnt(s1_gnt), .s1_pipe(s1_pipe)
   );

   // expected {g0,p0,g1,p1} from the requirement text
   function automatic logic [3:0] model(input logic v0, input logic [2:0] k0,
                                        input logic v1, input logic [2:0] k1,
                                        input logic hit);
      logic g0, p0, g1, p1, a_busy, b_busy;
      g0 = 1'b0; p0 = 1'b0; g1 = 1'b0; p1 = 1'b0;
      case (k0)
         3'd0, 3'd1, 3'd2, 3'd3: g0 = 1'b1;
         3'd4, 3'd5: begin g0 = 1'b1; p0 = 1'b1; end
         3'd6: g0 = !hit;
         default: g0 = 1'b0;
      endcase
      g0 = g0 & v0;
      if (!g0) p0 = 1'b0;
      a_busy = g0 && !p0;
      b_busy = g0 && p0;
      if (g0 && v1) begin
         case (k1)
            3'd0, 3'd3: g1 = !a_busy;
            3'd6: g1 = !a_busy && !hit;
            3'd4, 3'd5: begin g1 = !b_busy; p1 = 1'b1; end
            3'd1, 3'd2: begin
               if (!a_busy) g1 = 1'b1;
               else if (!b_busy && k0 != 3'd3) begin g1 = 1'b1; p1 = 1'b1; end
            end
            default: g1 = 1'b0;
         endcase
      end
      if (!g1) p1 = 1'b0;
      return {g0, p0, g1, p1};
   endfunction

   task automatic step(input logic v0, input logic [2:0] k0,
                       input logic v1, input logic [2:0] k1, input string req);
      logic [3:0] exp;
      logic push;
      @(negedge clk);
      s0_vld = v0; s0_op = k0; s1_vld = v1; s1_op = k1;
      #1;
      exp = model(v0, k0, v1, k1, mh[DIST-1]);
      checks++;
      if ({s0_gnt, s0_pipe, s1_gnt, s1_pipe} !== exp) begin
         fails++;
         $display("FAIL %s: ops v%0b/%0d v%0b/%0d got g0p0g1p1=%b expected %b",
                  req, v0, k0, v1, k1, {s0_gnt, s0_pipe, s1_gnt, s1_pipe}, exp);
      end
      push = (exp[3] && !exp[2] && k0 == 3'd1) || (exp[1] && !exp[0] && k1 == 3'd1);
      @(posedge clk);
      mh = {mh[DIST-2:0], push};
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 1'b0, 3'd0, "R10 idle");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      mh = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; s0_vld = 0; s1_vld = 0; s0_op = 0; s1_op = 0; mh = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      step(0, 3'd0, 0, 3'd0, "R10 reset idle");
      step(1, 3'd6, 0, 3'd0, "R6 short op right after reset");
      step(1, 3'd0, 1, 3'd0, "R1 R4 two vector integer");
      step(1, 3'd4, 1, 3'd5, "R2 R4 permute then store data");
      step(1, 3'd2, 1, 3'd2, "R3 two scalar FP");
      step(1, 3'd4, 1, 3'd1, "R3 vector FP behind permute takes A");
      step(1, 3'd3, 1, 3'd2, "R5 FP blocked beside four-input op");
      step(1, 3'd3, 1, 3'd1, "R5 vector FP blocked beside four-input op");
      step(1, 3'd3, 1, 3'd4, "R5 permute allowed beside four-input op");
      step(0, 3'd0, 1, 3'd0, "R7 idle older stalls younger");
      step(1, 3'd7, 1, 3'd0, "R8 R7 reserved older stalls younger");
      step(1, 3'd0, 1, 3'd7, "R8 reserved younger");
      idle(DIST + 1);

      for (int d = 1; d <= DIST + 2; d++) begin
         step(1, 3'd1, 0, 3'd0, "R6 vector FP on A");
         idle(d - 1);
         step(1, 3'd6, 1, 3'd4, "R6 R7 short op at distance");
         idle(DIST + 1);
      end
      step(1, 3'd1, 0, 3'd0, "R6 vector FP on A");
      idle(DIST - 1);
      step(1, 3'd4, 1, 3'd6, "R6 short op in younger slot at distance");
      idle(DIST + 1);
      step(1, 3'd2, 0, 3'd0, "R6 scalar FP does not arm");
      idle(DIST - 1);
      step(1, 3'd6, 0, 3'd0, "R6 short op after scalar FP");
      idle(DIST + 1);
      step(1, 3'd0, 1, 3'd1, "R6 vector FP on B");
      idle(DIST - 1);
      step(1, 3'd6, 0, 3'd0, "R6 short op after FP on B");
      idle(DIST + 1);

      step(1, 3'd1, 0, 3'd0, "R9 vector FP before reset");
      do_reset();
      idle(1);
      step(1, 3'd6, 0, 3'd0, "R9 short op after reset in old window");
      idle(DIST + 1);

      for (int i = 0; i < 256; i++)
         step(i[7], i[6:4], i[3], i[2:0], "R1 R2 R3 R4 R5 R7 R8 R10 sweep");
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         step(r[7] | r[6], r[5:3], r[2], r[1:0] == 2'd3 ? 3'd6 : {r[1], r[0], r[7]},
              "R3 R4 R5 R6 R7 mixed history");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule